// File: doc/BRIEF.md
# Soda Vending Credit Controller

This block is the credit-keeping state machine of a coin-operated soda dispenser. It holds the money inserted so far, which is always a multiple of 25 cents and never more than one dollar. Each clock cycle it can accept one action from the front panel: a quarter, a dollar bill, a request for a soda, or a request to get the money back. A soda costs 75 cents.

An action is taken only when its valid strobe is high. The controller then updates the held credit. It answers with single-cycle pulses: one for a vend, one for a refund together with the refunded amount, and one for a deposit it turned down so the coin or bill can be handed back. A deposit that would push the credit above one dollar is refused outright. It is never partly accepted. A purchase made from a full dollar leaves 25 cents of credit behind.

All outputs come from registers. The pulses and the new credit become visible together, one clock edge after the action is sampled.

Top module: `vend_ctrl`

## Requirements
- R1: The credit is shown as a 3-bit code (000=0, 001=25, 010=50, 011=75, 100=100 cents) on `credit_code`. `credit_cents` always equals 25 times that code.
- R2: Action code 00 (quarter) raises the code by one when it is below 100. At 100 the credit is unchanged.
- R3: Action code 01 (dollar) moves the credit from 0 to 100. At any other credit the state is left unchanged.
- R4: Action code 10 (soda) at 75 moves the credit to 0, and at 100 moves it to 25. At 0, 25 or 50 it leaves the state unchanged and raises no pulse.
- R5: Action code 11 (refund) moves the credit to 0 from any state. When the credit was nonzero, `refund_pulse` is high for one cycle and `refund_amt` carries the former credit in cents. At 0 no pulse is raised. `refund_amt` reads 0 whenever `refund_pulse` is low.
- R6: `vend_pulse` is high for exactly one cycle after each successful soda action, in the same cycle the reduced credit first appears.
- R7: A quarter at 100, or a dollar at nonzero credit, raises `reject_pulse` for one cycle. No other action does.
- R8: With `act_valid` low the credit holds and all three pulses stay low.
- R9: While `rst_n` is low at a rising clock edge, the credit goes to 0 and all pulses and `refund_amt` clear, whatever the action inputs are.
- R10: The credit code never exceeds 100 (code 100), and at most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_valid | input | 1 | Action strobe; the action code is sampled only while high |
| act_code | input | 2 | 00 quarter, 01 dollar, 10 soda, 11 refund |
| credit_code | output | 3 | Held credit as a step count of 25 cents |
| credit_cents | output | 7 | Held credit in cents |
| vend_pulse | output | 1 | One-cycle pulse: dispense a soda |
| refund_pulse | output | 1 | One-cycle pulse: return the credit |
| refund_amt | output | 7 | Cents being returned, valid with `refund_pulse` |
| reject_pulse | output | 1 | One-cycle pulse: hand back a refused deposit |

## Verification
The credit code is an output, so a wrong internal state shows at the ports in the cycle right after the faulty action. It also shows up later in the pulses: a state that is off by one step vends when it should not, or fails to vend, and it refunds the wrong amount. The bench puts the machine in each of the five credit states, applies each of the four actions plus an idle strobe, and compares the credit and every pulse one edge later. Directed cases cover reset in mid-credit, the pulse width, and a refund at zero.

// File: rtl/vend_pkg.sv
// Package: shared types for the vending credit controller.
// Assumes the front panel encodes its action as a 2-bit code.
package vend_pkg;

    typedef enum logic [1:0] {
        ACT_QUARTER = 2'b00,
        ACT_DOLLAR  = 2'b01,
        ACT_SODA    = 2'b10,
        ACT_REFUND  = 2'b11
    } act_e;

endpackage

// File: rtl/vend_next.sv
// Module: vend_next
// Pure next-state and event logic for the credit machine.
// Credit is a count of coin steps; the cap and the price are given in steps.
// Assumes cur never exceeds CAP_STEPS, which the state register guarantees.
module vend_next
    import vend_pkg::*;
#(
    parameter int STATE_W     = 3,
    parameter int CAP_STEPS   = 4,
    parameter int PRICE_STEPS = 3
) (
    input  logic [STATE_W-1:0] cur,
    input  logic               act_valid,
    input  act_e               act,
    output logic [STATE_W-1:0] nxt,
    output logic               do_vend,
    output logic               do_refund,
    output logic               do_reject
);

    localparam logic [STATE_W-1:0] FULL  = STATE_W'(CAP_STEPS);
    localparam logic [STATE_W-1:0] PRICE = STATE_W'(PRICE_STEPS);
    localparam logic [STATE_W-1:0] EMPTY = '0;

    // Decode one sampled action against the present credit.
    always_comb begin
        nxt       = cur;
        do_vend   = 1'b0;
        do_refund = 1'b0;
        do_reject = 1'b0;
        if (act_valid) begin
            unique case (act)
                ACT_QUARTER: begin
                    if (cur == FULL) do_reject = 1'b1;
                    else             nxt = cur + STATE_W'(1);
                end
                ACT_DOLLAR: begin
                    if (cur == EMPTY) nxt = FULL;
                    else              do_reject = 1'b1;
                end
                ACT_SODA: begin
                    if (cur >= PRICE) begin
                        nxt     = cur - PRICE;
                        do_vend = 1'b1;
                    end
                end
                ACT_REFUND: begin
                    nxt       = EMPTY;
                    do_refund = (cur != EMPTY);
                end
                default: nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/vend_out_reg.sv
// Module: vend_out_reg
// Registers the event pulses and the refund amount so that no input
// reaches an output without a flop. Assumes at most one event per cycle.
module vend_out_reg #(
    parameter int CENTS_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_vend,
    input  logic               do_refund,
    input  logic               do_reject,
    input  logic [CENTS_W-1:0] cur_cents,
    output logic               vend_pulse,
    output logic               refund_pulse,
    output logic [CENTS_W-1:0] refund_amt,
    output logic               reject_pulse
);

    // Capture this cycle's events as next cycle's one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vend_pulse   <= 1'b0;
            refund_pulse <= 1'b0;
            reject_pulse <= 1'b0;
            refund_amt   <= '0;
        end else begin
            vend_pulse   <= do_vend;
            refund_pulse <= do_refund;
            reject_pulse <= do_reject;
            refund_amt   <= do_refund ? cur_cents : '0;
        end
    end

endmodule

// File: rtl/vend_ctrl.sv
// Module: vend_ctrl (top)
// Credit controller for a soda dispenser: holds 0..CAP_STEPS coin steps,
// vends at PRICE_STEPS, refunds on demand and refuses deposits over the cap.
// Assumes one action per valid cycle and a synchronous active-low reset.
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int STEP_CENTS  = 25,
    parameter int CAP_STEPS   = 4,
    parameter int PRICE_STEPS = 3,
    localparam int STATE_W    = $clog2(CAP_STEPS + 1),
    localparam int CENTS_W    = $clog2(CAP_STEPS * STEP_CENTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_valid,
    input  logic [1:0]         act_code,
    output logic [STATE_W-1:0] credit_code,
    output logic [CENTS_W-1:0] credit_cents,
    output logic               vend_pulse,
    output logic               refund_pulse,
    output logic [CENTS_W-1:0] refund_amt,
    output logic               reject_pulse
);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic               ev_vend;
    logic               ev_refund;
    logic               ev_reject;

    vend_next #(
        .STATE_W     (STATE_W),
        .CAP_STEPS   (CAP_STEPS),
        .PRICE_STEPS (PRICE_STEPS)
    ) u_next (
        .cur       (state_q),
        .act_valid (act_valid),
        .act       (act_e'(act_code)),
        .nxt       (state_d),
        .do_vend   (ev_vend),
        .do_refund (ev_refund),
        .do_reject (ev_reject)
    );

    // Hold the credit step count.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Convert the step count to cents for display and refund.
    always_comb begin
        credit_cents = CENTS_W'(state_q) * CENTS_W'(STEP_CENTS);
    end

    assign credit_code = state_q;

    vend_out_reg #(
        .CENTS_W (CENTS_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .do_vend      (ev_vend),
        .do_refund    (ev_refund),
        .do_reject    (ev_reject),
        .cur_cents    (credit_cents),
        .vend_pulse   (vend_pulse),
        .refund_pulse (refund_pulse),
        .refund_amt   (refund_amt),
        .reject_pulse (reject_pulse)
    );

endmodule

// File: rtl/vend_ctrl_chk.sv
// Module: vend_ctrl_chk
// Property checker bound into vend_ctrl. It watches only the ports.
module vend_ctrl_chk #(
    parameter int STATE_W     = 3,
    parameter int CENTS_W     = 7,
    parameter int CAP_STEPS   = 4,
    parameter int PRICE_STEPS = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               act_valid,
    input logic [STATE_W-1:0] credit_code,
    input logic               vend_pulse,
    input logic               refund_pulse,
    input logic [CENTS_W-1:0] refund_amt,
    input logic               reject_pulse
);

    // R10: credit never above the cap
    p_credit_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        credit_code <= STATE_W'(CAP_STEPS));

    // R10: pulses are mutually exclusive
    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vend_pulse, refund_pulse, reject_pulse}));

    // R8: idle strobe holds credit and raises nothing
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |=> ($stable(credit_code) && !vend_pulse && !refund_pulse && !reject_pulse));

    // R4: a vend lowers the credit by exactly the price
    p_vend_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vend_pulse |-> (credit_code == $past(credit_code) - STATE_W'(PRICE_STEPS)));

    // R6: a vend pulse lasts one cycle
    p_vend_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vend_pulse |=> !vend_pulse);

    // R5: a refund empties the credit and returns a nonzero amount
    p_refund_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refund_pulse |-> (credit_code == '0 && refund_amt != '0));

    // R5: no amount outside a refund pulse
    p_refund_amt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !refund_pulse |-> (refund_amt == '0));

    // R7: a refused deposit leaves the credit alone
    p_reject_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reject_pulse |-> $stable(credit_code));

    // R9: reset clears credit and pulses
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (credit_code == '0 && !vend_pulse && !refund_pulse && !reject_pulse));

endmodule

bind vend_ctrl vend_ctrl_chk #(
    .STATE_W     (STATE_W),
    .CENTS_W     (CENTS_W),
    .CAP_STEPS   (CAP_STEPS),
    .PRICE_STEPS (PRICE_STEPS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_valid    (act_valid),
    .credit_code  (credit_code),
    .vend_pulse   (vend_pulse),
    .refund_pulse (refund_pulse),
    .refund_amt   (refund_amt),
    .reject_pulse (reject_pulse)
);

// File: tb/vend_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for vend_ctrl: a transition table walked by one loop, then directed cases.
module vend_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_valid = 1'b0;
    logic [1:0] act_code = 2'b00;
    logic [2:0] credit_code;
    logic [6:0] credit_cents;
    logic       vend_pulse;
    logic       refund_pulse;
    logic [6:0] refund_amt;
    logic       reject_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vend_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_valid    (act_valid),
        .act_code     (act_code),
        .credit_code  (credit_code),
        .credit_cents (credit_cents),
        .vend_pulse   (vend_pulse),
        .refund_pulse (refund_pulse),
        .refund_amt   (refund_amt),
        .reject_pulse (reject_pulse)
    );

    // Vector: start[11:9] act[8:7] valid[6] next[5:3] vend[2] refund[1] reject[0]
    localparam logic [11:0] VEC [25] = '{
        {3'd0, 2'b00, 1'b1, 3'd1, 3'b000},
        {3'd1, 2'b00, 1'b1, 3'd2, 3'b000},
        {3'd2, 2'b00, 1'b1, 3'd3, 3'b000},
        {3'd3, 2'b00, 1'b1, 3'd4, 3'b000},
        {3'd4, 2'b00, 1'b1, 3'd4, 3'b001},
        {3'd0, 2'b01, 1'b1, 3'd4, 3'b000},
        {3'd1, 2'b01, 1'b1, 3'd1, 3'b001},
        {3'd2, 2'b01, 1'b1, 3'd2, 3'b001},
        {3'd3, 2'b01, 1'b1, 3'd3, 3'b001},
        {3'd4, 2'b01, 1'b1, 3'd4, 3'b001},
        {3'd0, 2'b10, 1'b1, 3'd0, 3'b000},
        {3'd1, 2'b10, 1'b1, 3'd1, 3'b000},
        {3'd2, 2'b10, 1'b1, 3'd2, 3'b000},
        {3'd3, 2'b10, 1'b1, 3'd0, 3'b100},
        {3'd4, 2'b10, 1'b1, 3'd1, 3'b100},
        {3'd0, 2'b11, 1'b1, 3'd0, 3'b000},
        {3'd1, 2'b11, 1'b1, 3'd0, 3'b010},
        {3'd2, 2'b11, 1'b1, 3'd0, 3'b010},
        {3'd3, 2'b11, 1'b1, 3'd0, 3'b010},
        {3'd4, 2'b11, 1'b1, 3'd0, 3'b010},
        {3'd0, 2'b01, 1'b0, 3'd0, 3'b000},
        {3'd1, 2'b11, 1'b0, 3'd1, 3'b000},
        {3'd2, 2'b00, 1'b0, 3'd2, 3'b000},
        {3'd3, 2'b10, 1'b0, 3'd3, 3'b000},
        {3'd4, 2'b10, 1'b0, 3'd4, 3'b000}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one action at the falling edge; outputs are read just after the next rising edge.
    task automatic step(input logic vld, input logic [1:0] code);
        @(negedge clk);
        act_valid = vld;
        act_code  = code;
        @(posedge clk);
        #1;
        act_valid = 1'b0;
    endtask

    // Bring the credit to n steps by a refund and then n quarters.
    task automatic reach(input int n);
        step(1'b1, 2'b11);
        for (int i = 0; i < n; i++) step(1'b1, 2'b00);
    endtask

    task automatic check_all(input string req, input int code, input int v,
                             input int r, input int amt, input int j);
        chk({req, " credit_code"}, int'(credit_code), code);
        chk("R1 credit_cents", int'(credit_cents), code * 25);
        chk({req, " vend_pulse"}, int'(vend_pulse), v);
        chk({req, " refund_pulse"}, int'(refund_pulse), r);
        chk({req, " refund_amt"}, int'(refund_amt), amt);
        chk({req, " reject_pulse"}, int'(reject_pulse), j);
    endtask

    initial begin
        string tag;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check_all("R9", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Transition table walk: R2 quarter, R3 dollar, R4 soda, R5 refund, R7 reject, R8 idle
        for (int k = 0; k < 25; k++) begin
            logic [11:0] e;
            int start_s, exp_amt;
            e = VEC[k];
            start_s = int'(e[11:9]);
            case (e[8:7])
                2'b00: tag = "R2";
                2'b01: tag = "R3";
                2'b10: tag = "R4";
                default: tag = "R5";
            endcase
            if (!e[6]) tag = "R8";
            reach(start_s);
            chk("R1 setup credit_code", int'(credit_code), start_s);
            step(e[6], e[8:7]);
            exp_amt = e[1] ? start_s * 25 : 0;
            check_all(tag, int'(e[5:3]), int'(e[2]), int'(e[1]), exp_amt, int'(e[0]));
        end

        // R6: the vend pulse drops after one cycle, credit unchanged by idle
        reach(3);
        step(1'b1, 2'b10);
        chk("R6 vend high", int'(vend_pulse), 1);
        step(1'b0, 2'b10);
        chk("R6 vend one cycle", int'(vend_pulse), 0);
        chk("R6 credit after vend", int'(credit_code), 0);

        // R4: two sodas from 100: first vends to 25, second does nothing
        reach(4);
        step(1'b1, 2'b10);
        chk("R4 first soda", int'(credit_code), 1);
        step(1'b1, 2'b10);
        chk("R4 second soda vend", int'(vend_pulse), 0);
        chk("R4 second soda credit", int'(credit_code), 1);

        // R7: reject lasts one cycle
        reach(4);
        step(1'b1, 2'b00);
        chk("R7 reject high", int'(reject_pulse), 1);
        step(1'b0, 2'b00);
        chk("R7 reject one cycle", int'(reject_pulse), 0);

        // R10: repeated quarters never pass the cap
        for (int i = 0; i < 3; i++) step(1'b1, 2'b00);
        chk("R10 cap held", int'(credit_code), 4);

        // R9: reset in mid-credit overrides a valid action
        reach(2);
        @(negedge clk);
        rst_n = 1'b0;
        act_valid = 1'b1;
        act_code = 2'b01;
        @(posedge clk);
        #1;
        check_all("R9 mid", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        act_valid = 1'b0;
        step(1'b1, 2'b01);
        chk("R9 after reset dollar", int'(credit_code), 4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule